// File: doc/BRIEF.md
# I2C Master Status Flags and Interrupt Lines

This block keeps the status flags of an I2C master controller and turns them into two interrupt requests. The first request covers bus events. The second covers bus faults. A protocol engine, which is not part of this block, reports each bus event as a one-cycle pulse: start condition sent, address phase done, byte transfer finished, transmit holding register empty, receive holding register full, acknowledge failure, arbitration lost and bus error. It also gives the bus-busy state as a plain level. Each pulse sets a sticky flag in the primary status word. The busy level appears in the secondary status word.

Software reaches the block through a simple access port that selects one of four words. Reading or writing these words clears the flags as a side effect. Fault flags clear when software writes a zero to their bit. Event flags clear through access sequences that follow how a driver services the controller: first the primary status word is read, then the secondary status word is read or the data register is accessed. A control word holds three enables. They choose which flags can raise each interrupt line. The transmit and receive buffer flags reach the event line only when both the event enable and the buffer enable are set.

Top module: `i2c_stat_irq`

## Requirements
- R1: After reset, all flags are 0, the control word reads 0, the secondary status word is 0 and both interrupt outputs are low.
- R2: Each event pulse sets its flag on the next clock edge, at a fixed bit of primary status word (select 0): start sent bit 0, address done bit 1, byte finished bit 2, receive full bit 6, transmit empty bit 7, bus error bit 8, arbitration lost bit 9, acknowledge failure bit 10. All other bits read 0.
- R3: Bit 1 of the secondary status word (select 1) shows the bus-busy input, delayed by one clock. Its other bits read 0.
- R4: The control word (select 2) stores the error enable at bit 8, the event enable at bit 9 and the buffer enable at bit 10. Its other bits read 0. Reads of the data register (select 3) return 0.
- R5: Writing the primary status word clears each fault flag (bits 8, 9, 10) whose written bit is 0. A written 1 leaves that flag unchanged. The write has no effect on the event flags.
- R6: The address flag clears on a secondary status read only when the access just before it was a primary status read. Any other secondary status read leaves the flag set.
- R7: The start flag clears on a data register write only when the access just before it was a primary status read.
- R8: The receive-full flag clears on any data register read. The transmit-empty flag clears on any data register write. The byte-finished flag clears on a data register access only when the access just before it was a primary status read.
- R9: When a flag is set and cleared in the same cycle, the set wins and the flag stays 1.
- R10: The event interrupt is a registered level. One cycle after a flag change, it equals: event enable AND (start OR address OR byte-finished OR (buffer enable AND (transmit empty OR receive full))). It drops one cycle after its causes clear.
- R11: The error interrupt is a registered level. One cycle after a flag change, it equals: error enable AND (acknowledge failure OR arbitration lost OR bus error). It drops one cycle after its causes clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start_sent | input | 1 | Pulse: start condition generated |
| ev_addr_done | input | 1 | Pulse: address phase completed |
| ev_byte_done | input | 1 | Pulse: byte transfer finished |
| ev_rx_full | input | 1 | Pulse: receive holding register filled |
| ev_tx_empty | input | 1 | Pulse: transmit holding register emptied |
| ev_bus_err | input | 1 | Pulse: misplaced start or stop seen |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_ack_fail | input | 1 | Pulse: acknowledge not received |
| bus_busy | input | 1 | Level: a transfer is in progress on the bus |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | Word select: 0 primary status, 1 secondary status, 2 control, 3 data |
| acc_wdata | input | REG_W | Write data |
| acc_rdata | output | REG_W | Read data of the selected word (combinational) |
| stat1 | output | REG_W | Primary status word |
| stat2 | output | REG_W | Secondary status word |
| irq_event | output | 1 | Event interrupt request |
| irq_error | output | 1 | Error interrupt request |

## Verification
The assertions check on every cycle that the interrupt lines follow the previous cycle's flags and enables, that a set pulse always wins, that a fault flag holds until a zero is written to it, that the address flag survives any access other than an armed secondary read, and that the busy bit follows its input. The bench scenarios are needed for the rest. They show that the access sequences clear the flags only in the right order, that an access in between disarms the sequence, that the buffer enable gates the event line, and the exact bit layout of each word.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  localparam int NFLAG = 8;

  // internal flag indices
  localparam int F_SB   = 0;
  localparam int F_ADDR = 1;
  localparam int F_BTF  = 2;
  localparam int F_RXF  = 3;
  localparam int F_TXE  = 4;
  localparam int F_BERR = 5;
  localparam int F_ARL  = 6;
  localparam int F_AF   = 7;

  localparam int BUSY_POS   = 1;
  localparam int EN_ERR_POS = 8;
  localparam int EN_EVT_POS = 9;
  localparam int EN_BUF_POS = 10;
  localparam int MIN_REG_W  = 11;

  typedef enum logic [1:0] {
    SEL_ST1  = 2'd0,
    SEL_ST2  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_DATA = 2'd3
  } acc_sel_e;

  // bit position of a flag inside the primary status word
  function automatic int flag_pos(input int idx);
    case (idx)
      F_SB:    flag_pos = 0;
      F_ADDR:  flag_pos = 1;
      F_BTF:   flag_pos = 2;
      F_RXF:   flag_pos = 6;
      F_TXE:   flag_pos = 7;
      F_BERR:  flag_pos = 8;
      F_ARL:   flag_pos = 9;
      default: flag_pos = 10;
    endcase
  endfunction

  function automatic logic is_fault(input int idx);
    is_fault = (idx == F_BERR) || (idx == F_ARL) || (idx == F_AF);
  endfunction

  function automatic logic evt_cause(input logic [NFLAG-1:0] f,
                                     input logic en_evt, input logic en_buf);
    evt_cause = en_evt & (f[F_SB] | f[F_ADDR] | f[F_BTF] |
                          (en_buf & (f[F_TXE] | f[F_RXF])));
  endfunction

  function automatic logic err_cause(input logic [NFLAG-1:0] f, input logic en_err);
    err_cause = en_err & (f[F_AF] | f[F_ARL] | f[F_BERR]);
  endfunction

endpackage

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;   // hardware set has priority
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/i2c_acc_seq.sv
module i2c_acc_seq
  import i2c_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic [1:0] acc_sel,
  output logic       rd_st2,
  output logic       wr_st1,
  output logic       wr_ctrl,
  output logic       rd_data,
  output logic       wr_data,
  output logic       armed
);
  acc_sel_e sel;
  logic     rd_st1;

  assign sel     = acc_sel_e'(acc_sel);
  assign rd_st1  = acc_en & ~acc_wr & (sel == SEL_ST1);
  assign rd_st2  = acc_en & ~acc_wr & (sel == SEL_ST2);
  assign wr_st1  = acc_en &  acc_wr & (sel == SEL_ST1);
  assign wr_ctrl = acc_en &  acc_wr & (sel == SEL_CTRL);
  assign rd_data = acc_en & ~acc_wr & (sel == SEL_DATA);
  assign wr_data = acc_en &  acc_wr & (sel == SEL_DATA);

  // armed: the most recent access was a primary status read
  always_ff @(posedge clk) begin
    if (!rst_n)      armed <= 1'b0;
    else if (acc_en) armed <= rd_st1;
  end
endmodule

// File: rtl/i2c_irq_group.sv
module i2c_irq_group
  import i2c_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags,
  input  logic             en_evt,
  input  logic             en_buf,
  input  logic             en_err,
  output logic             irq_event,
  output logic             irq_error
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_event <= 1'b0;
      irq_error <= 1'b0;
    end else begin
      irq_event <= evt_cause(flags, en_evt, en_buf);
      irq_error <= err_cause(flags, en_err);
    end
  end
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_stat_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start_sent,
  input  logic             ev_addr_done,
  input  logic             ev_byte_done,
  input  logic             ev_rx_full,
  input  logic             ev_tx_empty,
  input  logic             ev_bus_err,
  input  logic             ev_arb_lost,
  input  logic             ev_ack_fail,
  input  logic             bus_busy,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [1:0]       acc_sel,
  input  logic [REG_W-1:0] acc_wdata,
  output logic [REG_W-1:0] acc_rdata,
  output logic [REG_W-1:0] stat1,
  output logic [REG_W-1:0] stat2,
  output logic             irq_event,
  output logic             irq_error
);
  localparam int CTRL_LSB = EN_ERR_POS;

  logic [NFLAG-1:0] set_vec, clr_vec, flags;
  logic rd_st2, wr_st1, wr_ctrl, rd_data, wr_data, armed;
  logic en_err, en_evt, en_buf, busy_q;
  logic [REG_W-1:0] ctrl_word;
  logic wdata_unused;

  assign wdata_unused = ^acc_wdata;

  assign set_vec[F_SB]   = ev_start_sent;
  assign set_vec[F_ADDR] = ev_addr_done;
  assign set_vec[F_BTF]  = ev_byte_done;
  assign set_vec[F_RXF]  = ev_rx_full;
  assign set_vec[F_TXE]  = ev_tx_empty;
  assign set_vec[F_BERR] = ev_bus_err;
  assign set_vec[F_ARL]  = ev_arb_lost;
  assign set_vec[F_AF]   = ev_ack_fail;

  i2c_acc_seq u_seq (
    .clk, .rst_n, .acc_en, .acc_wr, .acc_sel,
    .rd_st2, .wr_st1, .wr_ctrl, .rd_data, .wr_data, .armed
  );

  // clear conditions per flag
  genvar gi;
  generate
    for (gi = 0; gi < NFLAG; gi++) begin : g_flag
      if (is_fault(gi)) begin : g_fault
        assign clr_vec[gi] = wr_st1 & ~acc_wdata[flag_pos(gi)];
      end else if (gi == F_SB) begin : g_sb
        assign clr_vec[gi] = wr_data & armed;
      end else if (gi == F_ADDR) begin : g_addr
        assign clr_vec[gi] = rd_st2 & armed;
      end else if (gi == F_BTF) begin : g_btf
        assign clr_vec[gi] = (rd_data | wr_data) & armed;
      end else if (gi == F_RXF) begin : g_rxf
        assign clr_vec[gi] = rd_data;
      end else begin : g_txe
        assign clr_vec[gi] = wr_data;
      end

      i2c_stat_flag u_flag (
        .clk, .rst_n, .set(set_vec[gi]), .clr(clr_vec[gi]), .q(flags[gi])
      );
    end
  endgenerate

  // control enables and busy sample
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en_buf, en_evt, en_err} <= 3'b000;
      busy_q <= 1'b0;
    end else begin
      if (wr_ctrl) {en_buf, en_evt, en_err} <= acc_wdata[CTRL_LSB +: 3];
      busy_q <= bus_busy;
    end
  end

  always_comb begin
    stat1 = '0;
    for (int i = 0; i < NFLAG; i++) stat1[flag_pos(i)] = flags[i];
    stat2 = '0;
    stat2[BUSY_POS] = busy_q;
    ctrl_word = '0;
    ctrl_word[EN_ERR_POS] = en_err;
    ctrl_word[EN_EVT_POS] = en_evt;
    ctrl_word[EN_BUF_POS] = en_buf;
  end

  always_comb begin
    case (acc_sel_e'(acc_sel))
      SEL_ST1:  acc_rdata = stat1;
      SEL_ST2:  acc_rdata = stat2;
      SEL_CTRL: acc_rdata = ctrl_word;
      default:  acc_rdata = '0;
    endcase
  end

  i2c_irq_group u_irq (
    .clk, .rst_n, .flags, .en_evt, .en_buf, .en_err, .irq_event, .irq_error
  );
endmodule

// File: rtl/i2c_stat_irq_chk.sv
module i2c_stat_irq_chk
  import i2c_stat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ev_start_sent,
  input logic             ev_ack_fail,
  input logic             ev_bus_err,
  input logic             bus_busy,
  input logic             acc_en,
  input logic             acc_wr,
  input logic [1:0]       acc_sel,
  input logic             wd_berr,
  input logic [NFLAG-1:0] flags,
  input logic             busy_bit,
  input logic             armed,
  input logic             en_evt,
  input logic             en_buf,
  input logic             en_err,
  input logic             irq_event,
  input logic             irq_error
);
  a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_sent |=> flags[F_SB]);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_fail |=> flags[F_AF]);

  a_r5_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    flags[F_BERR] && !(acc_en && acc_wr && acc_sel == 2'd0 && !wd_berr) |=> flags[F_BERR]);

  a_r6_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    flags[F_ADDR] && !(acc_en && !acc_wr && acc_sel == 2'd1 && armed) |=> flags[F_ADDR]);

  a_r3_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> busy_bit == $past(bus_busy));

  a_r10_event_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_event == ($past(en_evt) && ($past(flags[F_SB]) || $past(flags[F_ADDR]) ||
      $past(flags[F_BTF]) || ($past(en_buf) && ($past(flags[F_TXE]) || $past(flags[F_RXF]))))));

  a_r11_error_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_error == ($past(en_err) && ($past(flags[F_AF]) || $past(flags[F_ARL]) ||
      $past(flags[F_BERR]))));

  a_r2_bus_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> flags[F_BERR]);
endmodule

bind i2c_stat_irq i2c_stat_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start_sent(ev_start_sent), .ev_ack_fail(ev_ack_fail),
  .ev_bus_err(ev_bus_err), .bus_busy(bus_busy), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_sel(acc_sel), .wd_berr(acc_wdata[8]), .flags(flags), .busy_bit(stat2[1]),
  .armed(armed), .en_evt(en_evt), .en_buf(en_buf), .en_err(en_err),
  .irq_event(irq_event), .irq_error(irq_error)
);

// File: tb/test_i2c_stat_irq.sv
module test_i2c_stat_irq;
  localparam int CLK_T = 10;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic [7:0] ev = '0; // 0 sb,1 addr,2 btf,3 rxf,4 txe,5 berr,6 arl,7 af
  logic bus_busy = 0, acc_en = 0, acc_wr = 0;
  logic [1:0] acc_sel = 0;
  logic [W-1:0] acc_wdata = '0, acc_rdata, stat1, stat2;
  logic irq_event, irq_error;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  i2c_stat_irq #(.REG_W(W)) i_i2c_stat_irq (
    .clk, .rst_n,
    .ev_start_sent(ev[0]), .ev_addr_done(ev[1]), .ev_byte_done(ev[2]),
    .ev_rx_full(ev[3]), .ev_tx_empty(ev[4]), .ev_bus_err(ev[5]),
    .ev_arb_lost(ev[6]), .ev_ack_fail(ev[7]), .bus_busy,
    .acc_en, .acc_wr, .acc_sel, .acc_wdata, .acc_rdata,
    .stat1, .stat2, .irq_event, .irq_error
  );

  // {buf,evt,err enables, events, exp event irq, exp error irq}
  localparam logic [12:0] TBL [10] = '{
    {3'b010, 8'b0000_0001, 1'b1, 1'b0},
    {3'b000, 8'b0000_0001, 1'b0, 1'b0},
    {3'b010, 8'b0001_0000, 1'b0, 1'b0},
    {3'b110, 8'b0000_1000, 1'b1, 1'b0},
    {3'b100, 8'b0001_0000, 1'b0, 1'b0},
    {3'b001, 8'b1000_0000, 1'b0, 1'b1},
    {3'b110, 8'b0010_0000, 1'b0, 1'b0},
    {3'b111, 8'b0100_0100, 1'b1, 1'b1},
    {3'b011, 8'b0000_0010, 1'b1, 1'b0},
    {3'b001, 8'b0000_1000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ev = '0; acc_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [W-1:0] d);
    acc_en = 1; acc_wr = 0; acc_sel = sel;
    #1 d = acc_rdata;
    @(negedge clk); acc_en = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    acc_en = 1; acc_wr = 1; acc_sel = sel; acc_wdata = d;
    @(negedge clk); acc_en = 0;
  endtask

  task automatic pulse(input logic [7:0] e);
    ev = e;
    @(negedge clk); ev = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    do_reset();
    // R1 reset state
    chk("R1 stat1", stat1, 16'h0);
    chk("R1 stat2", stat2, 16'h0);
    chk("R1 irqs", {14'h0, irq_event, irq_error}, 16'h0);
    rd(2'd2, d); chk("R1 ctrl", d, 16'h0);

    // R10 R11 table walk
    foreach (TBL[i]) begin
      do_reset();
      wr(2'd2, {5'b0, TBL[i][12:10], 8'h00});
      pulse(TBL[i][9:2]);
      @(negedge clk);
      chk($sformatf("R10 event line vec%0d", i), {15'h0, irq_event}, {15'h0, TBL[i][1]});
      chk($sformatf("R11 error line vec%0d", i), {15'h0, irq_error}, {15'h0, TBL[i][0]});
    end

    // R2 bit positions
    for (int k = 0; k < 8; k++) begin
      automatic int pos[8] = '{0, 1, 2, 6, 7, 8, 9, 10};
      do_reset();
      pulse(8'(1 << k));
      rd(2'd0, d);
      chk($sformatf("R2 flag%0d", k), d, 16'(1 << pos[k]));
    end

    // R3 busy
    do_reset();
    bus_busy = 1; @(negedge clk);
    rd(2'd1, d); chk("R3 busy high", d, 16'h0002);
    bus_busy = 0; @(negedge clk);
    chk("R3 busy low", stat2, 16'h0);

    // R4 control word and data read
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); chk("R4 ctrl mask", d, 16'h0700);
    rd(2'd3, d); chk("R4 data reads 0", d, 16'h0);

    // R5 fault clear by writing zero
    do_reset();
    pulse(8'b1110_0001);
    wr(2'd0, 16'hFBFF);
    chk("R5 af only cleared", stat1, 16'h0301);
    wr(2'd0, 16'hFFFF);
    chk("R5 write one keeps", stat1, 16'h0301);
    wr(2'd0, 16'h0000);
    chk("R5 zero clears faults not sb", stat1, 16'h0001);

    // R6 address flag sequence
    do_reset();
    pulse(8'b0000_0010);
    rd(2'd1, d);
    chk("R6 unarmed st2 read keeps", stat1, 16'h0002);
    rd(2'd0, d); rd(2'd3, d); rd(2'd1, d);
    chk("R6 disarmed by data read", stat1, 16'h0002);
    rd(2'd0, d); rd(2'd1, d);
    chk("R6 st1 then st2 clears", stat1, 16'h0000);

    // R7 start flag sequence
    do_reset();
    pulse(8'b0000_0001);
    wr(2'd3, 16'h00A5);
    chk("R7 unarmed data write keeps", stat1, 16'h0001);
    rd(2'd0, d); wr(2'd3, 16'h005A);
    chk("R7 st1 then data write clears", stat1, 16'h0000);

    // R8 buffer flags and byte finished
    do_reset();
    pulse(8'b0001_1100);
    rd(2'd3, d);
    chk("R8 data read clears rxf only", stat1, 16'h0084);
    wr(2'd3, 16'h0011);
    chk("R8 data write clears txe", stat1, 16'h0004);
    rd(2'd0, d); rd(2'd3, d);
    chk("R8 st1 then data clears btf", stat1, 16'h0000);

    // R9 set beats clear in same cycle
    do_reset();
    pulse(8'b1010_0000);
    acc_en = 1; acc_wr = 1; acc_sel = 2'd0; acc_wdata = 16'h0000; ev = 8'b1000_0000;
    @(negedge clk); acc_en = 0; ev = '0;
    chk("R9 set wins", stat1, 16'h0400);

    // R11 drop timing: line falls one cycle after clear
    wr(2'd2, 16'h0100);
    @(negedge clk);
    chk("R11 asserted", {15'h0, irq_error}, 16'h1);
    wr(2'd0, 16'h0000);
    chk("R11 still high same cycle", {15'h0, irq_error}, 16'h1);
    @(negedge clk);
    chk("R11 dropped next cycle", {15'h0, irq_error}, 16'h0);

    // R10 drop timing
    wr(2'd2, 16'h0200);
    pulse(8'b0000_0010);
    @(negedge clk);
    chk("R10 asserted", {15'h0, irq_event}, 16'h1);
    rd(2'd0, d); rd(2'd1, d);
    @(negedge clk);
    chk("R10 dropped", {15'h0, irq_event}, 16'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule